// File: doc/BRIEF.md
# Tachometer Timer Register Block

This block is the bus-facing register file of a two-channel tachometer timer. It decodes a 32-byte window. Every register in the window accepts one access width only, and a request of any other shape gets an error response. The block holds the configuration that the two measurement channels consume: the prescaler, the tick selects, the mode bits, the compare values and compare settings, and the input selects.

The block divides the core clock by a programmable ratio. Each channel has its own select bit that gates the resulting tick. The channels report capture, compare-hit and underflow events as single-cycle pulses. The block folds these pulses into six sticky pending flags and drives one level interrupt from them. The channels own the counter and capture values, and a read of those offsets passes the channel's value straight through.

Software clears pending flags only through a separate write-only clear register. Reset zeroes every configuration register and the pending flags. The counter and capture values are never touched because they are held outside this block.

Top module: `tach_regfile`

## Requirements
- R1: Address and lane check. Offsets 0x00, 0x02, 0x04, 0x06, 0x14 and 0x16 are 16-bit registers and accept only byte enables 2'b11. Offsets 0x08, 0x0A, 0x0C, 0x0E, 0x10, 0x12, 0x18, 0x1A and 0x1C are 8-bit registers and accept only byte enables 2'b01. Any other case is rejected: an odd address, offset 0x1E, or a mismatched enable. A rejected access returns error 1 with data 0 and changes no state.
- R2: A response (rsp_valid_o) appears in the cycle after each request and in no other cycle. The data and the error bit are registered with it.
- R3: After reset every configuration register reads 0, all pending flags are 0, irq_o is 0 and no tick is issued.
- R4: Reads of 0x00, 0x02, 0x04 and 0x06 return cnt_a_i, cap_a_i, cap_b_i and cnt_b_i respectively. Writes to these offsets are accepted without error and discarded.
- R5: A write to the clear register (0x10) clears each pending bit whose data bit is 1. The clear register reads as 0. A write to the pending register (0x0E) is accepted and has no effect.
- R6: Pending register layout, with the same positions used by the interrupt-enable register (0x12): bit 0 capture A, bit 1 capture B, bit 2 underflow A, bit 3 underflow B, bit 4 compare A, bit 5 compare B. An event pulse sets its bit at the next edge.
- R7: If an event sets a pending bit in the same cycle that the clear register clears it, the bit ends up set.
- R8: irq_o is high whenever some pending bit has its enable bit set. It rises the cycle after such an event.
- R9: Register 0x08 holds the prescale value P. While bit 0 or bit 3 of register 0x0A is set, one base tick is produced every P+1 cycles. tick_o[0] is gated by bit 0 and tick_o[1] by bit 3. The divider restarts when P is written and idles while both bits are clear.
- R10: Register 0x0C drives ch_en_o = {bit 6, bit 5}, ch_edge_o = {bit 4, bit 3} and mode5_o = bit 2. Register 0x18 drives cmp_cfg_a_o from bits 3:0 and cmp_cfg_b_o from bits 7:4. Bit 0 of 0x1A drives in_sel_o[0] and bit 0 of 0x1C drives in_sel_o[1]. Registers 0x14 and 0x16 drive cmp_a_o and cmp_b_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one access per cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 5 | Byte offset within the window |
| req_be_i | input | 2 | Byte enables |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 16 | Read data, 0 for writes and rejected accesses |
| rsp_err_o | output | 1 | Access rejected |
| cnt_a_i | input | 16 | Channel A counter value |
| cap_a_i | input | 16 | Channel A capture value |
| cap_b_i | input | 16 | Channel B capture value |
| cnt_b_i | input | 16 | Channel B counter value |
| cap_evt_i | input | 2 | Capture event pulses, bit 0 = A |
| udf_evt_i | input | 2 | Underflow event pulses, bit 0 = A |
| cmp_evt_i | input | 2 | Compare-hit event pulses, bit 0 = A |
| tick_o | output | 2 | Gated prescaled tick enables, bit 0 = A |
| ch_en_o | output | 2 | Channel enables |
| ch_edge_o | output | 2 | Channel edge selects |
| mode5_o | output | 1 | Capture mode select |
| cmp_a_o | output | 16 | Channel A compare value |
| cmp_b_o | output | 16 | Channel B compare value |
| cmp_cfg_a_o | output | 4 | Channel A compare settings |
| cmp_cfg_b_o | output | 4 | Channel B compare settings |
| in_sel_o | output | 2 | Input selects, bit 0 = A |
| irq_o | output | 1 | Level interrupt |

## Verification
Accesses are tried at every legal width and then with each wrong enable pattern, an odd address and the undefined offset 0x1E. This separates rejection from a silent write, because each rejected access is followed by a read-back. Event pulses are sent one at a time on every source, so a swapped pending position shows up. A clear and an event are then sent in the same cycle, which tells set-priority from clear-priority. The prescaler is run at ratios 4 and 1 with each select combination, and counting ticks over a fixed window tells the period apart from the per-channel gating.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned NUM_EVT  = 3 * NUM_CH;
  localparam int unsigned IDX_W    = ADDR_W - 1;

  typedef enum logic [IDX_W-1:0] {
    IDX_CNT_A  = 4'd0,
    IDX_CAP_A  = 4'd1,
    IDX_CAP_B  = 4'd2,
    IDX_CNT_B  = 4'd3,
    IDX_PRESC  = 4'd4,
    IDX_CLKSEL = 4'd5,
    IDX_MODE   = 4'd6,
    IDX_PEND   = 4'd7,
    IDX_CLR    = 4'd8,
    IDX_IRQEN  = 4'd9,
    IDX_CMP_A  = 4'd10,
    IDX_CMP_B  = 4'd11,
    IDX_CMPCFG = 4'd12,
    IDX_SEL_A  = 4'd13,
    IDX_SEL_B  = 4'd14,
    IDX_NONE   = 4'd15
  } reg_idx_e;

  // tick select positions in the clock-select register
  localparam int unsigned CLKSEL_A_BIT = 0;
  localparam int unsigned CLKSEL_B_BIT = 3;
  // mode register fields
  localparam int unsigned MODE_EN_B_BIT   = 6;
  localparam int unsigned MODE_EN_A_BIT   = 5;
  localparam int unsigned MODE_EDGE_B_BIT = 4;
  localparam int unsigned MODE_EDGE_A_BIT = 3;
  localparam int unsigned MODE_M5_BIT     = 2;
  localparam int unsigned CFG_W           = 4;
endpackage

// File: rtl/tach_access.sv
module tach_access
  import tach_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  output reg_idx_e          idx_o,
  output logic              ok_o
);
  logic wide;
  logic defined;

  always_comb begin
    idx_o   = addr_i[0] ? IDX_NONE : reg_idx_e'(addr_i[ADDR_W-1:1]);
    defined = !addr_i[0] && (idx_o != IDX_NONE);
    wide    = (idx_o inside {IDX_CNT_A, IDX_CAP_A, IDX_CAP_B, IDX_CNT_B,
                             IDX_CMP_A, IDX_CMP_B});
    ok_o    = defined && (wide ? (be_i == 2'b11) : (be_i == 2'b01));
  end
endmodule

// File: rtl/tach_presc.sv
module tach_presc #(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned NUM_CH  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               restart_i,
  input  logic [NUM_CH-1:0]  ch_sel_i,
  output logic [NUM_CH-1:0]  tick_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic run;
  logic base_tick;

  assign run       = |ch_sel_i;
  assign base_tick = run && (cnt_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (restart_i || !run || base_tick) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_gate
    assign tick_o[k] = base_tick & ch_sel_i[k];
  end

  // after a ratio change the first tick is a full new period away
  p_restart_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ((tick_o == '0) || (presc_i == '0)))
    else $error("R9 tick right after restart");
endmodule

// File: rtl/tach_irq.sv
module tach_irq #(
  parameter int unsigned NUM_EVT = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic [NUM_EVT-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0))
    else $error("R5 pending bit survived clear");

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)))
    else $error("R7 event lost");

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & en_i)) |=> (irq_o || (($past(set_i) & en_i) == '0)))
    else $error("R8 enabled event without interrupt");
endmodule

// File: rtl/tach_regfile.sv
module tach_regfile
  import tach_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [1:0]          req_be_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o,
  input  logic [DATA_W-1:0]   cnt_a_i,
  input  logic [DATA_W-1:0]   cap_a_i,
  input  logic [DATA_W-1:0]   cap_b_i,
  input  logic [DATA_W-1:0]   cnt_b_i,
  input  logic [NUM_CH-1:0]   cap_evt_i,
  input  logic [NUM_CH-1:0]   udf_evt_i,
  input  logic [NUM_CH-1:0]   cmp_evt_i,
  output logic [NUM_CH-1:0]   tick_o,
  output logic [NUM_CH-1:0]   ch_en_o,
  output logic [NUM_CH-1:0]   ch_edge_o,
  output logic                mode5_o,
  output logic [DATA_W-1:0]   cmp_a_o,
  output logic [DATA_W-1:0]   cmp_b_o,
  output logic [CFG_W-1:0]    cmp_cfg_a_o,
  output logic [CFG_W-1:0]    cmp_cfg_b_o,
  output logic [NUM_CH-1:0]   in_sel_o,
  output logic                irq_o
);
  reg_idx_e idx;
  logic     ok;
  logic     wr_ok;
  logic [NARROW_W-1:0] wbyte;

  logic [NARROW_W-1:0] presc_q, clksel_q, mode_q, cmpcfg_q;
  logic [NUM_EVT-1:0]  irqen_q;
  logic [DATA_W-1:0]   cmp_a_q, cmp_b_q;
  logic                sel_a_q, sel_b_q;

  logic [NUM_EVT-1:0]  evt_set, evt_clr, pend;
  logic [DATA_W-1:0]   rd_val;

  logic                rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0]   rsp_data_q;

  tach_access u_access (
    .addr_i (req_addr_i),
    .be_i   (req_be_i),
    .idx_o  (idx),
    .ok_o   (ok)
  );

  assign wr_ok = req_valid_i && req_write_i && ok;
  assign wbyte = req_wdata_i[NARROW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q  <= '0;
      clksel_q <= '0;
      mode_q   <= '0;
      irqen_q  <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
      cmpcfg_q <= '0;
      sel_a_q  <= 1'b0;
      sel_b_q  <= 1'b0;
    end else if (wr_ok) begin
      case (idx)
        IDX_PRESC:  presc_q  <= wbyte;
        IDX_CLKSEL: clksel_q <= wbyte;
        IDX_MODE:   mode_q   <= wbyte;
        IDX_IRQEN:  irqen_q  <= wbyte[NUM_EVT-1:0];
        IDX_CMP_A:  cmp_a_q  <= req_wdata_i;
        IDX_CMP_B:  cmp_b_q  <= req_wdata_i;
        IDX_CMPCFG: cmpcfg_q <= wbyte;
        IDX_SEL_A:  sel_a_q  <= wbyte[0];
        IDX_SEL_B:  sel_b_q  <= wbyte[0];
        default: ;
      endcase
    end
  end

  // event vector: captures, then underflows, then compare hits
  for (genvar k = 0; k < NUM_CH; k++) begin : g_evt
    assign evt_set[k]            = cap_evt_i[k];
    assign evt_set[NUM_CH+k]     = udf_evt_i[k];
    assign evt_set[2*NUM_CH+k]   = cmp_evt_i[k];
  end

  assign evt_clr = (wr_ok && idx == IDX_CLR) ? wbyte[NUM_EVT-1:0] : '0;

  tach_irq #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .en_i   (irqen_q),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  tach_presc #(.PRESC_W(NARROW_W), .NUM_CH(NUM_CH)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .presc_i   (presc_q),
    .restart_i (wr_ok && idx == IDX_PRESC),
    .ch_sel_i  ({clksel_q[CLKSEL_B_BIT], clksel_q[CLKSEL_A_BIT]}),
    .tick_o    (tick_o)
  );

  always_comb begin
    case (idx)
      IDX_CNT_A:  rd_val = cnt_a_i;
      IDX_CAP_A:  rd_val = cap_a_i;
      IDX_CAP_B:  rd_val = cap_b_i;
      IDX_CNT_B:  rd_val = cnt_b_i;
      IDX_PRESC:  rd_val = DATA_W'(presc_q);
      IDX_CLKSEL: rd_val = DATA_W'(clksel_q);
      IDX_MODE:   rd_val = DATA_W'(mode_q);
      IDX_PEND:   rd_val = DATA_W'(pend);
      IDX_IRQEN:  rd_val = DATA_W'(irqen_q);
      IDX_CMP_A:  rd_val = cmp_a_q;
      IDX_CMP_B:  rd_val = cmp_b_q;
      IDX_CMPCFG: rd_val = DATA_W'(cmpcfg_q);
      IDX_SEL_A:  rd_val = DATA_W'(sel_a_q);
      IDX_SEL_B:  rd_val = DATA_W'(sel_b_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i && !ok;
      rsp_data_q  <= (req_valid_i && !req_write_i && ok) ? rd_val : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_data_q;

  assign ch_en_o     = {mode_q[MODE_EN_B_BIT], mode_q[MODE_EN_A_BIT]};
  assign ch_edge_o   = {mode_q[MODE_EDGE_B_BIT], mode_q[MODE_EDGE_A_BIT]};
  assign mode5_o     = mode_q[MODE_M5_BIT];
  assign cmp_a_o     = cmp_a_q;
  assign cmp_b_o     = cmp_b_q;
  assign cmp_cfg_a_o = cmpcfg_q[CFG_W-1:0];
  assign cmp_cfg_b_o = cmpcfg_q[2*CFG_W-1:CFG_W];
  assign in_sel_o    = {sel_b_q, sel_a_q};

  p_bad_lane_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_be_i[0]) |=> (rsp_err_o && rsp_rdata_o == '0))
    else $error("R1 bad lane accepted");

  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o)
    else $error("R2 missing response");

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o)
    else $error("R2 spurious response");

  p_clr_reads_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == 5'h10 && req_be_i == 2'b01)
      |=> (!rsp_err_o && rsp_rdata_o == '0))
    else $error("R5 clear register read nonzero");
endmodule

// File: tb/tb_tach_regfile.sv
module tb_tach_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [4:0]  req_addr = 0;
  logic [1:0]  req_be = 0;
  logic [15:0] req_wdata = 0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [15:0] cnt_a = 0, cap_a = 0, cap_b = 0, cnt_b = 0;
  logic [1:0]  cap_evt = 0, udf_evt = 0, cmp_evt = 0;
  logic [1:0]  tick, ch_en, ch_edge, in_sel;
  logic        mode5, irq;
  logic [15:0] cmp_a, cmp_b;
  logic [3:0]  cfg_a, cfg_b;

  tach_regfile dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .cnt_a_i(cnt_a), .cap_a_i(cap_a), .cap_b_i(cap_b), .cnt_b_i(cnt_b),
    .cap_evt_i(cap_evt), .udf_evt_i(udf_evt), .cmp_evt_i(cmp_evt),
    .tick_o(tick), .ch_en_o(ch_en), .ch_edge_o(ch_edge), .mode5_o(mode5),
    .cmp_a_o(cmp_a), .cmp_b_o(cmp_b), .cmp_cfg_a_o(cfg_a), .cmp_cfg_b_o(cfg_b),
    .in_sel_o(in_sel), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] last_rd;
  logic        last_err;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_presc, m_clk, m_mode, m_cfg;
  logic [5:0]  m_pend, m_ien;
  logic [15:0] m_cmpa, m_cmpb, m_rd;
  logic        m_sela, m_selb, m_rv, m_re;
  int          m_pc;

  function automatic logic [15:0] m_read(input int i);
    case (i)
      0: return cnt_a;   1: return cap_a;   2: return cap_b;  3: return cnt_b;
      4: return {8'h0, m_presc};  5: return {8'h0, m_clk};
      6: return {8'h0, m_mode};   7: return {10'h0, m_pend};
      9: return {10'h0, m_ien};   10: return m_cmpa;  11: return m_cmpb;
      12: return {8'h0, m_cfg};   13: return {15'h0, m_sela};
      14: return {15'h0, m_selb};
      default: return 16'h0;
    endcase
  endfunction

  function automatic bit m_run();
    return m_clk[0] | m_clk[3];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_presc = 0; m_clk = 0; m_mode = 0; m_cfg = 0; m_pend = 0; m_ien = 0;
      m_cmpa = 0; m_cmpb = 0; m_sela = 0; m_selb = 0; m_pc = 0;
      m_rv = 0; m_re = 0; m_rd = 0;
    end else begin
      bit run, t, ok, wide, restart;
      int idx;
      logic [5:0] clr;
      run = m_run();
      t = run && (m_pc == int'(m_presc));
      clr = 0; restart = 0;
      m_rv = req_valid; m_re = 0; m_rd = 0;
      if (req_valid) begin
        idx  = req_addr[0] ? 15 : int'(req_addr[4:1]);
        wide = (idx <= 3) || idx == 10 || idx == 11;
        ok   = (idx != 15) && (wide ? req_be == 2'b11 : req_be == 2'b01);
        if (!ok) m_re = 1;
        else if (!req_write) m_rd = m_read(idx);
        else case (idx)
          4:  begin m_presc = req_wdata[7:0]; restart = 1; end
          5:  m_clk  = req_wdata[7:0];
          6:  m_mode = req_wdata[7:0];
          8:  clr    = req_wdata[5:0];
          9:  m_ien  = req_wdata[5:0];
          10: m_cmpa = req_wdata;
          11: m_cmpb = req_wdata;
          12: m_cfg  = req_wdata[7:0];
          13: m_sela = req_wdata[0];
          14: m_selb = req_wdata[0];
          default: ;
        endcase
      end
      m_pend = (m_pend & ~clr) | {cmp_evt, udf_evt, cap_evt};
      m_pc = (restart || !run || t) ? 0 : m_pc + 1;
    end
  end

  // lockstep comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit t;
      t = m_run() && (m_pc == int'(m_presc));
      check("R1 err", rsp_err, m_re);
      check("R2 valid", rsp_valid, m_rv);
      check("R4 rdata", rsp_rdata, m_rd);
      check("R9 tick", tick, {t & m_clk[3], t & m_clk[0]});
      check("R8 irq", irq, |(m_pend & m_ien));
      check("R10 en/edge/m5", {ch_en, ch_edge, mode5}, {m_mode[6], m_mode[5], m_mode[4], m_mode[3], m_mode[2]});
      check("R10 cmp", {cmp_a, cmp_b}, {m_cmpa, m_cmpb});
      check("R10 cfg/sel", {cfg_b, cfg_a, in_sel}, {m_cfg, m_selb, m_sela});
    end
  end

  task automatic bus(input bit wr, input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    last_rd = rsp_rdata; last_err = rsp_err;
  endtask

  task automatic pulse(input logic [1:0] c, input logic [1:0] u, input logic [1:0] m);
    cap_evt = c; udf_evt = u; cmp_evt = m;
    @(negedge clk);
    cap_evt = 0; udf_evt = 0; cmp_evt = 0;
  endtask

  task automatic count_ticks(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c0 += int'(tick[0]); c1 += int'(tick[1]);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    check("R3 irq", irq, 0);
    check("R3 tick", tick, 0);
    check("R3 cmp", {cmp_a, cmp_b, cfg_a, cfg_b}, 0);
    bus(0, 5'h08, 2'b01, 0); check("R3 presc", last_rd, 0);
    bus(0, 5'h0E, 2'b01, 0); check("R3 pend", last_rd, 0);
    bus(0, 5'h0C, 2'b01, 0); check("R3 mode", last_rd, 0);

    // R10 field mapping
    bus(1, 5'h0C, 2'b01, 16'h007C);
    bus(1, 5'h18, 2'b01, 16'h00A5);
    bus(1, 5'h1A, 2'b01, 16'h0001);
    bus(1, 5'h14, 2'b11, 16'h1234);
    bus(1, 5'h16, 2'b11, 16'hCAFE);
    check("R10 en", ch_en, 2'b11);
    check("R10 edge", ch_edge, 2'b11);
    check("R10 mode5", mode5, 1);
    check("R10 cfg a", cfg_a, 4'h5);
    check("R10 cfg b", cfg_b, 4'hA);
    check("R10 sel", in_sel, 2'b01);
    check("R10 cmp a", cmp_a, 16'h1234);
    bus(0, 5'h0C, 2'b01, 0); check("R10 mode readback", last_rd, 16'h007C);

    // R1 rejected shapes leave state unchanged
    bus(1, 5'h08, 2'b11, 16'h0055); check("R1 wide to narrow", last_err, 1);
    bus(0, 5'h08, 2'b01, 0);        check("R1 presc untouched", last_rd, 0);
    bus(1, 5'h14, 2'b01, 16'h00FF); check("R1 narrow to wide", last_err, 1);
    check("R1 cmp untouched", cmp_a, 16'h1234);
    bus(0, 5'h1E, 2'b01, 0);        check("R1 undefined offset", last_err, 1);
    bus(0, 5'h09, 2'b01, 0);        check("R1 odd address", last_err, 1);
    bus(1, 5'h08, 2'b10, 16'h0300); check("R1 upper lane", last_err, 1);
    bus(0, 5'h00, 2'b01, 0);        check("R1 narrow read of wide", {last_err, last_rd}, 17'h10000);
    bus(0, 5'h12, 2'b00, 0);        check("R1 no lanes", last_err, 1);

    // R4 read-through of channel values
    cnt_a = 16'hBEEF; cap_a = 16'h0A0A; cap_b = 16'h0B0B; cnt_b = 16'h7777;
    bus(0, 5'h00, 2'b11, 0); check("R4 cnt a", last_rd, 16'hBEEF);
    bus(0, 5'h02, 2'b11, 0); check("R4 cap a", last_rd, 16'h0A0A);
    bus(0, 5'h04, 2'b11, 0); check("R4 cap b", last_rd, 16'h0B0B);
    bus(0, 5'h06, 2'b11, 0); check("R4 cnt b", last_rd, 16'h7777);
    bus(1, 5'h00, 2'b11, 16'h1111); check("R4 write ok", last_err, 0);
    bus(0, 5'h00, 2'b11, 0); check("R4 write discarded", last_rd, 16'hBEEF);

    // R6 pending positions
    pulse(2'b10, 0, 0);      bus(0, 5'h0E, 2'b01, 0); check("R6 cap b bit1", last_rd, 16'h02);
    pulse(0, 2'b01, 0);      bus(0, 5'h0E, 2'b01, 0); check("R6 udf a bit2", last_rd, 16'h06);
    pulse(0, 0, 2'b10);      bus(0, 5'h0E, 2'b01, 0); check("R6 cmp b bit5", last_rd, 16'h26);
    pulse(2'b01, 2'b10, 2'b01); bus(0, 5'h0E, 2'b01, 0); check("R6 all", last_rd, 16'h3F);

    // R5 clear behaviour
    bus(1, 5'h0E, 2'b01, 16'h0000); check("R5 pend write ok", last_err, 0);
    bus(0, 5'h0E, 2'b01, 0);        check("R5 pend write ignored", last_rd, 16'h3F);
    bus(1, 5'h10, 2'b01, 16'h0005);
    bus(0, 5'h0E, 2'b01, 0);        check("R5 partial clear", last_rd, 16'h3A);
    bus(0, 5'h10, 2'b01, 0);        check("R5 clear reads zero", last_rd, 0);
    bus(1, 5'h10, 2'b01, 16'h003F);
    bus(0, 5'h0E, 2'b01, 0);        check("R5 full clear", last_rd, 0);

    // R8 interrupt level
    pulse(2'b01, 0, 0);  check("R8 disabled", irq, 0);
    bus(1, 5'h12, 2'b01, 16'h0001); check("R8 enable after pending", irq, 1);
    bus(1, 5'h10, 2'b01, 16'h0001); check("R8 drop on clear", irq, 0);
    bus(1, 5'h12, 2'b01, 16'h0020);
    pulse(0, 0, 2'b10);  check("R8 rise next cycle", irq, 1);
    bus(1, 5'h10, 2'b01, 16'h0020); check("R8 cleared", irq, 0);

    // R7 set beats clear in the same cycle
    cap_evt = 2'b10;
    bus(1, 5'h10, 2'b01, 16'h003F);
    cap_evt = 0;
    bus(0, 5'h0E, 2'b01, 0); check("R7 set wins", last_rd, 16'h02);
    bus(1, 5'h10, 2'b01, 16'h003F);

    // R9 prescaler and gating
    bus(1, 5'h08, 2'b01, 16'h0003);
    bus(1, 5'h0A, 2'b01, 16'h0001);
    count_ticks(16, c0, c1); check("R9 ratio4 a", c0, 4); check("R9 ratio4 b gated", c1, 0);
    bus(1, 5'h0A, 2'b01, 16'h0009);
    count_ticks(16, c0, c1); check("R9 both a", c0, 4); check("R9 both b", c1, 4);
    bus(1, 5'h0A, 2'b01, 16'h0008);
    count_ticks(16, c0, c1); check("R9 only b a", c0, 0); check("R9 only b b", c1, 4);
    bus(1, 5'h08, 2'b01, 16'h0000);
    count_ticks(10, c0, c1); check("R9 ratio1", c1, 10);
    bus(1, 5'h0A, 2'b01, 16'h0000);
    count_ticks(10, c0, c1); check("R9 stopped", c0 + c1, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule